// File: doc/BRIEF.md
# Delay-Swept Eye Capture Sequencer

This block runs one equivalent-time eye capture across a single bit period. It walks a programmable sampling-delay code upward from zero, one position at a time. Each new code goes to an external delay latch together with a one-cycle strobe. After a programmable number of ADC words has been discarded so that the delay and the converter pipeline can settle, it collects a fixed number of ADC words at that position. Every collected word leaves as a record tagged with the index of the delay position it was taken at.

Records leave through a single-slot valid/ready output. Back-pressure rules: a record, once presented, stays on the port unchanged until the consumer takes it. The ADC cannot be stalled, so a word that arrives while the slot is full and not being emptied is lost and counted. A position is complete only after the required number of words has actually been accepted. A host starts a sweep with a start pulse, which also samples the configuration. It can stop the sweep at any time with an abort pulse.

Top module: `eye_sweep_ctrl`

## Requirements
- R1: A start pulse while idle samples cfg_steps, cfg_samples and cfg_settle and begins a sweep at position 0. Changes to those inputs during the sweep have no effect on it.
- R2: Each position is announced by dly_code taking the position index together with dly_strobe high for exactly one cycle. Positions run 0, 1, ..., cfg_steps-1. dly_code changes only alongside the strobe or on abort.
- R3: After each strobe, the first cfg_settle ADC words with adc_valid high in the cycles following the strobe cycle are discarded. The word in the strobe cycle is also discarded. With cfg_settle = 0, collection starts in the cycle right after the strobe.
- R4: Exactly cfg_samples words are delivered per position. Each record is out_data = {index[7:0] in bits 21:14, sample[13:0] in bits 13:0}. Within a position, samples appear in arrival order.
- R5: out_valid stays high with out_data and out_last unchanged until out_ready is high. An ADC word can enter the slot only in a cycle when the slot is empty or out_ready is high.
- R6: A collection-phase ADC word that finds the slot full with out_ready low is dropped. It increments ovf_count, which saturates at its maximum and is cleared by start. Dropped words do not count toward cfg_samples.
- R7: out_last is high on exactly one record per completed sweep: the last sample of position cfg_steps-1.
- R8: After the final position, busy falls and done rises, and both stay that way. The next start clears done and raises busy. busy and done are never high together.
- R9: Abort, from any state, makes busy low and dly_code zero in the next cycle. Abort does not set done and takes precedence over a start in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one ADC word per cycle at most |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sweep (idle only) |
| abort | input | 1 | Stop the sweep and return the delay code to zero |
| cfg_steps | input | 9 | Number of delay positions (1 to 256) |
| cfg_samples | input | 10 | Samples collected per position (at least 1) |
| cfg_settle | input | 4 | ADC words discarded after each delay update |
| dly_code | output | 8 | Delay control word for the external latch |
| dly_strobe | output | 1 | One-cycle load strobe for dly_code |
| adc_data | input | 14 | ADC sample word |
| adc_valid | input | 1 | adc_data holds a new word this cycle |
| out_valid | output | 1 | Output record present |
| out_ready | input | 1 | Consumer takes the record this cycle |
| out_data | output | 22 | Record {index, sample} |
| out_last | output | 1 | Record is the final one of the sweep |
| busy | output | 1 | A sweep is in progress |
| done | output | 1 | Last sweep completed |
| ovf_count | output | 16 | Words lost to a full output slot since start |

## Verification
The bench aims at the accounting across settle and back-pressure. The ADC input is a counting ramp, so every gap between consecutive delivered samples shows exactly how many words were thrown away. A design that discarded one settle word too many or too few would shift the first sample of every position. A design that counted dropped words as samples would deliver short positions, and one that dropped words without counting them would make the sum of gaps disagree with ovf_count. Further runs cover zero settle, configuration changes made mid-sweep, the single out_last, done being cleared by start, and an abort arriving together with a start, which a wrong priority would turn into a fresh sweep.

// File: rtl/eye_sweep_pkg.sv
package eye_sweep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SETTLE,
    ST_COLLECT,
    ST_NEXT,
    ST_DONE
  } sweep_st_e;
endpackage

// File: rtl/eye_sweep_seq.sv
module eye_sweep_seq
  import eye_sweep_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CNT_W = 10,
  parameter int SET_W = 4,
  localparam int STEP_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [STEP_W-1:0] cfg_steps,
  input  logic [CNT_W-1:0]  cfg_samples,
  input  logic [SET_W-1:0]  cfg_settle,
  input  logic              adc_valid,
  input  logic              slot_free,
  output logic [IDX_W-1:0]  dly_code,
  output logic              dly_strobe,
  output logic              take,
  output logic              miss,
  output logic              take_last,
  output logic              go,
  output logic              busy,
  output logic              done
);
  sweep_st_e         st;
  logic [STEP_W-1:0] steps_q;
  logic [CNT_W-1:0]  samples_q;
  logic [SET_W-1:0]  settle_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  code_q;
  logic [CNT_W-1:0]  smp_cnt;
  logic [SET_W-1:0]  set_cnt;
  logic              done_q;
  logic              pos_last;
  logic              smp_last;

  assign pos_last  = ({1'b0, idx_q} == steps_q - STEP_W'(1));
  assign smp_last  = (smp_cnt == samples_q - CNT_W'(1));
  assign take      = (st == ST_COLLECT) && adc_valid && slot_free;
  assign miss      = (st == ST_COLLECT) && adc_valid && !slot_free;
  assign take_last = take && smp_last && pos_last;
  assign go        = (st == ST_IDLE) && start && !abort;
  assign dly_code  = code_q;
  assign dly_strobe = (st == ST_LOAD);
  assign busy      = (st != ST_IDLE);
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      steps_q   <= '0;
      samples_q <= '0;
      settle_q  <= '0;
      idx_q     <= '0;
      code_q    <= '0;
      smp_cnt   <= '0;
      set_cnt   <= '0;
      done_q    <= 1'b0;
    end else if (abort) begin
      st     <= ST_IDLE;
      code_q <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            steps_q   <= cfg_steps;
            samples_q <= cfg_samples;
            settle_q  <= cfg_settle;
            idx_q     <= '0;
            code_q    <= '0;
            done_q    <= 1'b0;
            st        <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          set_cnt <= '0;
          smp_cnt <= '0;
          st      <= (settle_q == '0) ? ST_COLLECT : ST_SETTLE;
        end
        ST_SETTLE: begin
          if (adc_valid) begin
            set_cnt <= set_cnt + SET_W'(1);
            if (set_cnt == settle_q - SET_W'(1)) st <= ST_COLLECT;
          end
        end
        ST_COLLECT: begin
          if (take) begin
            smp_cnt <= smp_cnt + CNT_W'(1);
            if (smp_last) st <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          if (pos_last) begin
            st <= ST_DONE;
          end else begin
            idx_q  <= idx_q + IDX_W'(1);
            code_q <= idx_q + IDX_W'(1);
            st     <= ST_LOAD;
          end
        end
        ST_DONE: begin
          done_q <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_code_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_code != $past(dly_code)) |-> (dly_strobe || $past(abort)));

  assert_strobe_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dly_strobe |=> !dly_strobe);

  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && dly_code == '0));

  assert_done_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));
endmodule

// File: rtl/eye_sweep_outbuf.sv
module eye_sweep_outbuf #(
  parameter int REC_W = 22,
  parameter int OVF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [REC_W-1:0] load_data,
  input  logic             load_last,
  input  logic             miss,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [REC_W-1:0] out_data,
  output logic             out_last,
  output logic             slot_free,
  output logic [OVF_W-1:0] ovf_count
);
  localparam logic [OVF_W-1:0] OVF_MAX = '1;

  logic             v_q;
  logic [REC_W-1:0] d_q;
  logic             l_q;
  logic [OVF_W-1:0] ovf_q;

  assign slot_free = !v_q || out_ready;
  assign out_valid = v_q;
  assign out_data  = d_q;
  assign out_last  = l_q;
  assign ovf_count = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      d_q <= '0;
      l_q <= 1'b0;
    end else if (load) begin
      v_q <= 1'b1;
      d_q <= load_data;
      l_q <= load_last;
    end else if (out_ready) begin
      v_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) ovf_q <= '0;
    else if (miss && ovf_q != OVF_MAX) ovf_q <= ovf_q + OVF_W'(1);
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_ovf_mono_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (ovf_count >= $past(ovf_count)));
endmodule

// File: rtl/eye_sweep_ctrl.sv
module eye_sweep_ctrl #(
  parameter int IDX_W = 8,
  parameter int SMP_W = 14,
  parameter int CNT_W = 10,
  parameter int SET_W = 4,
  parameter int OVF_W = 16,
  localparam int STEP_W = IDX_W + 1,
  localparam int REC_W = IDX_W + SMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [STEP_W-1:0] cfg_steps,
  input  logic [CNT_W-1:0]  cfg_samples,
  input  logic [SET_W-1:0]  cfg_settle,
  output logic [IDX_W-1:0]  dly_code,
  output logic              dly_strobe,
  input  logic [SMP_W-1:0]  adc_data,
  input  logic              adc_valid,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [REC_W-1:0]  out_data,
  output logic              out_last,
  output logic              busy,
  output logic              done,
  output logic [OVF_W-1:0]  ovf_count
);
  logic take, miss, take_last, go, slot_free;

  eye_sweep_seq #(.IDX_W(IDX_W), .CNT_W(CNT_W), .SET_W(SET_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .cfg_steps(cfg_steps), .cfg_samples(cfg_samples), .cfg_settle(cfg_settle),
    .adc_valid(adc_valid), .slot_free(slot_free),
    .dly_code(dly_code), .dly_strobe(dly_strobe),
    .take(take), .miss(miss), .take_last(take_last), .go(go),
    .busy(busy), .done(done)
  );

  eye_sweep_outbuf #(.REC_W(REC_W), .OVF_W(OVF_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(go),
    .load(take), .load_data({dly_code, adc_data}), .load_last(take_last),
    .miss(miss), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .slot_free(slot_free), .ovf_count(ovf_count)
  );
endmodule

// File: tb/eye_sweep_ctrl_tb.sv
`timescale 1ns/1ps
module eye_sweep_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, abort = 1'b0;
  logic [8:0]  cfg_steps = '0;
  logic [9:0]  cfg_samples = '0;
  logic [3:0]  cfg_settle = '0;
  logic [7:0]  dly_code;
  logic        dly_strobe;
  logic [13:0] adc_data = '0;
  logic        adc_valid = 1'b1;
  logic        out_valid, out_ready = 1'b1, out_last, busy, done;
  logic [21:0] out_data;
  logic [15:0] ovf_count;

  int checks = 0, errors = 0;
  int cyc = 0;
  bit bp_mode = 0, mon_en = 0, strict = 0;
  int s_steps, s_samples, s_settle;
  int exp_strobe, rec_no, drop_sum, prev, last_seen;
  int anchor [0:255];

  always #2.5 clk = ~clk;

  eye_sweep_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .cfg_steps(cfg_steps), .cfg_samples(cfg_samples), .cfg_settle(cfg_settle),
    .dly_code(dly_code), .dly_strobe(dly_strobe),
    .adc_data(adc_data), .adc_valid(adc_valid),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .busy(busy), .done(done), .ovf_count(ovf_count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ramp ADC and ready pattern, driven just after each rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    adc_data <= adc_data + 14'd1;
    if (bp_mode) out_ready <= !((cyc % 16) < 4 || (cyc % 7) == 3);
    else out_ready <= 1'b1;
  end

  // monitor on falling edge
  always @(negedge clk) begin
    if (mon_en && dly_strobe) begin
      chk(dly_code == 8'(exp_strobe), "R2 strobe code", dly_code, exp_strobe);
      anchor[dly_code] = int'(adc_data);
      exp_strobe++;
    end
    if (mon_en && out_valid && out_ready) begin
      int idx, smp, k, gap;
      idx = int'(out_data[21:14]);
      smp = int'(out_data[13:0]);
      k = rec_no % s_samples;
      chk(idx == rec_no / s_samples, "R4 record index", idx, rec_no / s_samples);
      chk(out_last == (rec_no == s_steps * s_samples - 1), "R7 last flag", out_last, rec_no == s_steps * s_samples - 1);
      if (k == 0) gap = smp - (anchor[idx] + s_settle + 1);
      else gap = smp - prev - 1;
      if (strict) chk(gap == 0, "R3 sample position", smp, smp - gap);
      else chk(gap >= 0, "R6 sample order", gap, 0);
      drop_sum += gap;
      if (out_last) last_seen++;
      prev = smp;
      rec_no++;
    end
  end

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic run_sweep(input int st, input int sm, input int se, input bit bp, input bit chg);
    cfg_steps = 9'(st); cfg_samples = 10'(sm); cfg_settle = 4'(se);
    s_steps = st; s_samples = sm; s_settle = se;
    exp_strobe = 0; rec_no = 0; drop_sum = 0; last_seen = 0;
    bp_mode = bp; strict = !bp; mon_en = 1;
    pulse_start();
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b1, "R8 start clears done", done, 0);
    chk(ovf_count == 16'd0, "R6 ovf cleared by start", ovf_count, 0);
    if (chg) begin
      cfg_steps = 9'd7; cfg_samples = 10'd5; cfg_settle = 4'd3;
    end
    begin
      int t;
      t = 0;
      while (!done && t < 20000) begin @(negedge clk); t++; end
      if (t >= 20000) begin
        errors++; checks++;
        $display("FAIL R8 watchdog actual=%0d expected=%0d", t, 20000);
      end
    end
    bp_mode = 0;
    repeat (10) @(negedge clk);
    chk(rec_no == st * sm, chg ? "R1 latched config count" : "R4 record count", rec_no, st * sm);
    chk(exp_strobe == st, "R2 position count", exp_strobe, st);
    chk(last_seen == 1, "R7 single last", last_seen, 1);
    chk(int'(ovf_count) == drop_sum, "R6 overflow equals lost words", ovf_count, drop_sum);
    chk(done && !busy, "R8 done after sweep", {busy, done}, 1);
    mon_en = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(dly_code == 0 && !dly_strobe, "R2 reset code", dly_code, 0);
    chk(!out_valid && !busy && !done, "R8 reset status", {out_valid, busy, done}, 0);
    chk(ovf_count == 0, "R6 reset ovf", ovf_count, 0);

    run_sweep(5, 3, 2, 0, 0);
    chk(ovf_count == 0, "R5 no loss without backpressure", ovf_count, 0);
    run_sweep(6, 4, 1, 1, 0);
    chk(ovf_count > 0, "R6 loss under backpressure", ovf_count, 1);
    run_sweep(4, 2, 0, 0, 1);
    run_sweep(3, 5, 3, 1, 0);

    // abort mid-sweep, with a start in the same cycle
    cfg_steps = 9'd5; cfg_samples = 10'd3; cfg_settle = 4'd2;
    pulse_start();
    repeat (12) @(posedge clk);
    #1 abort = 1'b1; start = 1'b1;
    @(posedge clk); #1 abort = 1'b0; start = 1'b0;
    @(negedge clk);
    chk(!busy, "R9 abort idles", busy, 0);
    chk(dly_code == 0, "R9 abort zero code", dly_code, 0);
    chk(!done, "R9 abort no done", done, 0);
    repeat (10) @(negedge clk);
    chk(!busy && !dly_strobe, "R9 abort beats start", busy, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #900000;
    errors++; checks++;
    $display("FAIL R8 global watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule